// File: doc/BRIEF.md
# Per-Pixel Bunch-Crossing Hit Stamp Buffer

This block is the digital memory that sits in each pixel of a collider tracking sensor. A global bunch-crossing number, 14 bits wide, goes to every pixel, together with a strobe that marks each crossing. During a bunch train, each crossing in which the pixel's threshold comparator reports a hit stores the current crossing number in the next free slot of a small local memory. The memory has `SLOTS` entries: four in the full build and two in the reduced build. A train lasts a few thousand crossings.

Stored stamps are read out only in the gap between trains. With the train-active input low, the block raises `nonEmpty` while unread stamps remain. Each read-acknowledge pulse returns the oldest unread stamp with a one-cycle valid bit. A hit that finds every slot taken is dropped and sets a sticky overflow flag. A train-start pulse clears the memory, the fill count, the read position and the overflow flag before the next train begins.

Top module: `hit_stamp_buffer`

## Requirements
- R1: While `rstN` is low and just after it rises, `nonEmpty`, `overflow` and `stampValid` are low.
- R2: A stamp is stored only in a cycle where `bunchStrobe` is high and was low in the previous cycle, and `trainActive` and `hitIn` are both high. The stored value is `bunchCount` in that cycle.
- R3: A hit that stays high while the strobe is held high for several cycles stores exactly one stamp.
- R4: With `trainActive` low, hits store nothing.
- R5: Once `SLOTS` stamps are held, further hits in the train are dropped and `overflow` goes high. `overflow` stays high until a train-start pulse.
- R6: `nonEmpty` is high exactly when `trainActive` is low and stored stamps remain unread.
- R7: `readAck` high while `nonEmpty` is high makes `stampValid` high for one cycle in the next cycle. `stampOut` then carries the oldest unread stamp, so stamps come out in capture order. `readAck` has no effect while `nonEmpty` is low.
- R8: A `trainStart` pulse discards all stamps and clears `overflow` and `nonEmpty` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for capture and readout |
| rstN | input | 1 | Active-low synchronous reset |
| trainActive | input | 1 | High during a bunch train |
| trainStart | input | 1 | One-cycle pulse that clears the buffer |
| bunchStrobe | input | 1 | High at each bunch crossing; its rising edge marks the crossing |
| bunchCount | input | STAMP_W (14) | Global bunch-crossing number |
| hitIn | input | 1 | Comparator output of the pixel |
| readAck | input | 1 | Read-acknowledge pulse from the readout controller |
| nonEmpty | output | 1 | Unread stamps are present (between trains only) |
| overflow | output | 1 | Sticky flag: a hit was lost because the buffer was full |
| stampOut | output | STAMP_W (14) | Stamp being read out |
| stampValid | output | 1 | `stampOut` is valid this cycle |

## Verification
The assertions assume that `trainStart` is a single-cycle pulse given while no read is in progress. They also assume the readout controller raises `readAck` only between trains.

The stimulus drives all inputs on the falling clock edge. It issues `trainStart` only outside readout and holds `readAck` for one cycle per request. It also sends one acknowledge after the buffer is empty, to show that such an acknowledge is ignored. Hits go in as held strobes, as isolated crossings and as crossings with `trainActive` low. This covers in-order capture, holding a hit over several cycles, overflow and clearing.

// File: rtl/hit_stamp_pkg.sv
package hit_stamp_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic clear;   // wipe all slots
    logic wrEn;    // store bunch number in slot wrIdx
    logic rdEn;    // present slot rdIdx on the output
  } ctrlStrobes_t;
endpackage

// File: rtl/hit_stamp_ctrl.sv
module hit_stamp_ctrl
  import hit_stamp_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trainActive,
  input  logic             trainStart,
  input  logic             bunchStrobe,
  input  logic             hitIn,
  input  logic             readAck,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic             nonEmpty,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SLOTS);

  logic             strobePrev;
  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] readPtr;
  logic             ovfFlag;
  logic             strobeRise;
  logic             captureReq;
  logic             isFull;

  always_comb begin
    strobeRise    = bunchStrobe && !strobePrev;
    captureReq    = strobeRise && trainActive && hitIn;
    isFull        = (fillCnt == FULL_CNT);
    nonEmpty      = !trainActive && (readPtr != fillCnt);
    strobes.clear = trainStart;
    strobes.wrEn  = captureReq && !isFull && !trainStart;
    strobes.rdEn  = readAck && nonEmpty && !trainStart;
    wrIdx         = fillCnt[IDX_W-1:0];
    rdIdx         = readPtr[IDX_W-1:0];
    overflow      = ovfFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobePrev <= 1'b0;
      fillCnt    <= '0;
      readPtr    <= '0;
      ovfFlag    <= 1'b0;
    end else begin
      strobePrev <= bunchStrobe;
      if (trainStart) begin
        fillCnt <= '0;
        readPtr <= '0;
        ovfFlag <= 1'b0;
      end else begin
        if (strobes.wrEn) fillCnt <= fillCnt + 1'b1;
        if (captureReq && isFull) ovfFlag <= 1'b1;
        if (strobes.rdEn) readPtr <= readPtr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hit_stamp_dp.sv
module hit_stamp_dp
  import hit_stamp_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int STAMP_W = 14,
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic [STAMP_W-1:0] bunchCount,
  output logic [STAMP_W-1:0] stampOut,
  output logic               stampValid
);
  logic [STAMP_W-1:0] slotMem [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN || strobes.clear) slotMem[s] <= '0;
      else if (strobes.wrEn && (wrIdx == IDX_W'(s))) slotMem[s] <= bunchCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stampOut   <= '0;
      stampValid <= 1'b0;
    end else begin
      stampValid <= strobes.rdEn;
      if (strobes.rdEn) stampOut <= slotMem[rdIdx];
    end
  end
endmodule

// File: rtl/hit_stamp_buffer.sv
module hit_stamp_buffer
  import hit_stamp_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int STAMP_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trainActive,
  input  logic               trainStart,
  input  logic               bunchStrobe,
  input  logic [STAMP_W-1:0] bunchCount,
  input  logic               hitIn,
  input  logic               readAck,
  output logic               nonEmpty,
  output logic               overflow,
  output logic [STAMP_W-1:0] stampOut,
  output logic               stampValid
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;

  hit_stamp_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .trainActive(trainActive), .trainStart(trainStart),
    .bunchStrobe(bunchStrobe), .hitIn(hitIn), .readAck(readAck),
    .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .nonEmpty(nonEmpty), .overflow(overflow)
  );

  hit_stamp_dp #(.SLOTS(SLOTS), .STAMP_W(STAMP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .bunchCount(bunchCount), .stampOut(stampOut), .stampValid(stampValid)
  );
endmodule

// File: rtl/hit_stamp_buffer_chk.sv
module hit_stamp_buffer_chk #(
  parameter int STAMP_W = 14
) (
  input logic               clk,
  input logic               rstN,
  input logic               trainActive,
  input logic               trainStart,
  input logic               readAck,
  input logic               nonEmpty,
  input logic               overflow,
  input logic [STAMP_W-1:0] stampOut,
  input logic               stampValid
);
  // R1: outputs quiet while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !stampValid && !overflow);

  // R6: nothing is offered for reading during a train
  a_r6_no_read_in_train: assert property (@(posedge clk) disable iff (!rstN)
    trainActive |-> !nonEmpty);

  // R7: a valid stamp follows an accepted acknowledge only
  a_r7_valid_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    stampValid |-> $past(readAck) && $past(nonEmpty));

  // R7: an acknowledge while empty produces nothing
  a_r7_idle_ack: assert property (@(posedge clk) disable iff (!rstN)
    readAck && !nonEmpty |=> !stampValid);

  // R5: overflow is sticky until a train start
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !trainStart |=> overflow);

  // R8: train start empties the buffer
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    trainStart |=> !overflow && !nonEmpty);
endmodule

bind hit_stamp_buffer hit_stamp_buffer_chk #(.STAMP_W(STAMP_W)) u_chk (
  .clk(clk), .rstN(rstN), .trainActive(trainActive), .trainStart(trainStart),
  .readAck(readAck), .nonEmpty(nonEmpty), .overflow(overflow),
  .stampOut(stampOut), .stampValid(stampValid)
);

// File: tb/hit_stamp_buffer_bench.sv
`timescale 1ns/1ps
module hit_stamp_buffer_bench;
  localparam int SLOTS = 4;
  localparam int SW    = 14;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          trainActive = 1'b0;
  logic          trainStart = 1'b0;
  logic          bunchStrobe = 1'b0;
  logic [SW-1:0] bunchCount = '0;
  logic          hitIn = 1'b0;
  logic          readAck = 1'b0;
  logic          nonEmpty, overflow, stampValid;
  logic [SW-1:0] stampOut;

  int testsRun = 0;
  int testsFailed = 0;
  int storedCnt = 0;
  logic [SW-1:0] expQ[$];

  always #2.5 clk = ~clk;

  hit_stamp_buffer #(.SLOTS(SLOTS), .STAMP_W(SW)) u_hit_stamp_buffer (
    .clk(clk), .rstN(rstN), .trainActive(trainActive), .trainStart(trainStart),
    .bunchStrobe(bunchStrobe), .bunchCount(bunchCount), .hitIn(hitIn),
    .readAck(readAck), .nonEmpty(nonEmpty), .overflow(overflow),
    .stampOut(stampOut), .stampValid(stampValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compare each presented stamp with the scoreboard head (R7)
  always @(negedge clk) begin
    if (rstN && stampValid) begin
      if (expQ.size() == 0) check("R7 unexpected stamp", 32'(stampOut), 32'hFFFF_FFFF);
      else check("R7 stamp order", 32'(stampOut), 32'(expQ.pop_front()));
    end
  end

  // Driver: one bunch crossing, strobe and hit held for 'hold' cycles
  task automatic bunch(input logic [SW-1:0] bc, input logic hit, input int hold);
    @(negedge clk);
    bunchCount  = bc;
    bunchStrobe = 1'b1;
    hitIn       = hit;
    if (hit && trainActive && storedCnt < SLOTS) begin
      expQ.push_back(bc);
      storedCnt++;
    end
    repeat (hold) @(negedge clk);
    bunchStrobe = 1'b0;
    hitIn       = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    readAck = 1'b1;
    @(negedge clk);
    readAck = 1'b0;
  endtask

  task automatic newTrain();
    @(negedge clk);
    trainStart = 1'b1;
    @(negedge clk);
    trainStart = 1'b0;
    trainActive = 1'b1;
    storedCnt = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 nonEmpty in reset", 32'(nonEmpty), 0);
    check("R1 overflow in reset", 32'(overflow), 0);
    check("R1 stampValid in reset", 32'(stampValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 nonEmpty after reset", 32'(nonEmpty), 0);

    // R4: hits before the train are ignored
    bunch(14'h0011, 1'b1, 1);
    @(negedge clk);
    check("R4 off-train hit stores nothing", 32'(nonEmpty), 0);

    // Train 1: three hits, one held over several cycles (R2, R3)
    newTrain();
    bunch(14'h0100, 1'b1, 1);
    bunch(14'h0101, 1'b0, 1);
    bunch(14'h0102, 1'b1, 4);
    bunch(14'h3FFF, 1'b1, 1);
    @(negedge clk);
    check("R6 nonEmpty low in train", 32'(nonEmpty), 0);
    trainActive = 1'b0;
    @(negedge clk);
    check("R6 nonEmpty after train", 32'(nonEmpty), 1);
    check("R5 no overflow with 3 hits", 32'(overflow), 0);
    bunch(14'h0200, 1'b1, 1);           // R4: between trains, ignored
    for (int i = 0; i < 3; i++) ack();
    @(negedge clk);
    check("R3 R2 R4 drained exactly three", 32'(expQ.size()), 0);
    check("R6 nonEmpty after drain", 32'(nonEmpty), 0);
    ack();                              // R7: ignored acknowledge
    @(negedge clk);
    check("R7 idle ack gives no stamp", 32'(stampValid), 0);

    // Train 2: overflow (R5)
    newTrain();
    for (int i = 0; i < SLOTS + 2; i++) bunch(SW'(14'h0400 + i), 1'b1, 1);
    @(negedge clk);
    check("R5 overflow set", 32'(overflow), 1);
    trainActive = 1'b0;
    for (int i = 0; i < SLOTS; i++) ack();
    @(negedge clk);
    check("R5 only SLOTS stamps kept", 32'(expQ.size()), 0);
    check("R5 overflow still set", 32'(overflow), 1);
    check("R6 empty after overflow drain", 32'(nonEmpty), 0);

    // Train 3: partial content then clear (R8)
    newTrain();
    bunch(14'h0777, 1'b1, 1);
    bunch(14'h0778, 1'b1, 1);
    trainActive = 1'b0;
    @(negedge clk);
    check("R6 nonEmpty with two stamps", 32'(nonEmpty), 1);
    expQ.delete();
    @(negedge clk);
    trainStart = 1'b1;
    @(negedge clk);
    trainStart = 1'b0;
    check("R8 nonEmpty cleared", 32'(nonEmpty), 0);
    check("R8 overflow cleared", 32'(overflow), 0);
    ack();
    @(negedge clk);
    check("R8 no stamp after clear", 32'(stampValid), 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule